// File: doc/BRIEF.md
# Multicycle Bus Processor

This block is a small register-machine core built around one shared 8-bit bus. It has eight 8-bit general registers, two temporary registers (an operand latch A and a result latch B), an instruction register and a 2-bit step counter. Each instruction word arrives on the data input. An optional immediate word follows it on the same input in the next cycle. The core runs each instruction over a fixed number of clock cycles and then returns to the fetch step.

Moves and immediate loads take two cycles. Add and subtract take four cycles:
- latch Rx into A;
- put Ry on the bus and form A plus or minus the bus into B;
- drive B back into Rx.

Subtraction uses the adder, with the bus operand inverted and a carry-in of one. The bus value is brought out on a port, so a test environment or a display stage can watch each transfer. The core holds no program memory: whatever drives the data input supplies the instruction stream.

Top module: `bus_proc`

## Requirements
- R1: An instruction word is taken from din_i in step 0. Its bits [7:6] are the opcode, bits [5:3] name the destination Rx and bits [2:0] name the source Ry. Rx and Ry are independent, so any pair of registers may be used.
- R2: Opcode 00 (move) takes two cycles. In step 1 the bus carries Ry, Rx is written with that value and done_o is high. Ry is left unchanged.
- R3: Opcode 01 (load immediate) takes two cycles. In step 1 the bus carries din_i, Rx captures that word and done_o is high.
- R4: Opcode 10 (add) takes four cycles and leaves (Rx + Ry) mod 256 in Rx.
- R5: Opcode 11 (subtract) takes four cycles and leaves (Rx + ~Ry + 1) mod 256 in Rx.
- R6: bus_o carries din_i in step 0. For add and subtract it carries Rx in step 1, Ry in step 2 and the result in step 3.
- R7: While run_i is low, the step counter holds and no register is written (general, instruction, A or B), and done_o stays low. Raising run_i again resumes at the held step.
- R8: After reset the core is at step 0, every general register reads zero and done_o is low.
- R9: done_o is high only in the final step of an instruction, and only while run_i is high: step 1 for opcodes 00 and 01, step 3 for opcodes 10 and 11.
- R10: When Rx equals Ry, add doubles the register and subtract clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Advance enable; low freezes the sequence |
| din_i | input | 8 | Instruction word, or immediate word in the second cycle of a load immediate |
| done_o | output | 1 | High in the last cycle of each instruction |
| bus_o | output | 8 | Current value on the internal bus |

## Verification
The assertions assume that din_i carries a valid instruction word in every step-0 cycle where run_i is high. They also assume the immediate word arrives in the cycle right after a load-immediate opcode. Every bit pattern is a legal instruction, so the stimulus only has to keep that cycle alignment. Each bench task drives exactly the number of cycles the opcode takes, with the instruction word in the first cycle. Register contents are read back through the bus during a move of a register onto itself, which leaves the register file unchanged.

// File: rtl/proc_pkg.sv
package proc_pkg;
  typedef enum logic [1:0] {
    OP_MV  = 2'b00,
    OP_MVI = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    BUS_DIN  = 2'd0,
    BUS_REG  = 2'd1,
    BUS_TMPB = 2'd2
  } bus_src_e;
endpackage

// File: rtl/proc_ctrl.sv
module proc_ctrl
  import proc_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] din_i,
  output bus_src_e      bus_src_o,
  output logic [RW-1:0] rsel_o,
  output logic [RW-1:0] wsel_o,
  output logic          reg_we_o,
  output logic          a_we_o,
  output logic          b_we_o,
  output logic          sub_o,
  output logic          done_o
);
  localparam int OPW   = 2;
  localparam int STEPW = 2;

  logic [DW-1:0]    ir_q;
  logic [STEPW-1:0] step_q, step_d;
  op_e              op;
  logic [RW-1:0]    rx, ry;
  logic             wr, a_ld, b_ld, last;

  assign op = op_e'(ir_q[DW-1 -: OPW]);
  assign rx = ir_q[2*RW-1 -: RW];
  assign ry = ir_q[RW-1:0];

  // bus selection follows the step regardless of run; only writes are gated
  always_comb begin
    bus_src_o = BUS_DIN;
    rsel_o    = ry;
    wsel_o    = rx;
    wr        = 1'b0;
    a_ld      = 1'b0;
    b_ld      = 1'b0;
    last      = 1'b0;
    step_d    = step_q;
    unique case (step_q)
      2'd0: step_d = 2'd1;
      2'd1: begin
        if (op == OP_MV) begin
          bus_src_o = BUS_REG;
          wr        = 1'b1;
          last      = 1'b1;
        end else if (op == OP_MVI) begin
          wr   = 1'b1;
          last = 1'b1;
        end else begin
          bus_src_o = BUS_REG;
          rsel_o    = rx;
          a_ld      = 1'b1;
          step_d    = 2'd2;
        end
      end
      2'd2: begin
        bus_src_o = BUS_REG;
        b_ld      = 1'b1;
        step_d    = 2'd3;
      end
      default: begin
        bus_src_o = BUS_TMPB;
        wr        = 1'b1;
        last      = 1'b1;
      end
    endcase
    if (last) step_d = '0;
  end

  assign reg_we_o = run_i & wr;
  assign a_we_o   = run_i & a_ld;
  assign b_we_o   = run_i & b_ld;
  assign done_o   = run_i & last;
  assign sub_o    = (op == OP_SUB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      ir_q   <= '0;
    end else if (run_i) begin
      step_q <= step_d;
      if (step_q == '0) ir_q <= din_i;
    end
  end

  AST_RUN_LOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(step_q) && $stable(ir_q)); // R7
  AST_IR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_q == 2'd0) |=> ir_q == $past(din_i)); // R1
  AST_MOVE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_q == 2'd1 && (op == OP_MV || op == OP_MVI)) |=> step_q == 2'd0); // R2
  AST_ALU_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_q == 2'd3) |=> step_q == 2'd0); // R4
  AST_DONE_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_i && step_q != 2'd0); // R9
endmodule

// File: rtl/proc_regfile.sv
module proc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wsel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] rsel_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]   regs_q [NREG];
  logic [NREG-1:0] we_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign we_vec[g] = we_i && (wsel_i == RW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[g] <= '0;
      else if (we_vec[g]) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[rsel_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wsel_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/proc_alu.sv
module proc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] b_eff;
  logic [DW-1:0] cin;
  logic [DW-1:0] ref_w;

  assign b_eff  = b_i ^ {DW{sub_i}};
  assign cin[0] = sub_i;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign res_o[g] = a_i[g] ^ b_eff[g] ^ cin[g];
    if (g < DW - 1) begin : g_carry
      assign cin[g+1] = (a_i[g] & b_eff[g]) | (cin[g] & (a_i[g] ^ b_eff[g]));
    end
  end

  always_comb begin
    ref_w = sub_i ? (a_i - b_i) : (a_i + b_i);
    AST_SUM_MATCH: assert (res_o == ref_w); // R5
  end
endmodule

// File: rtl/bus_proc.sv
module bus_proc
  import proc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] din_i,
  output logic          done_o,
  output logic [DW-1:0] bus_o
);
  localparam int RW = $clog2(NREG);

  bus_src_e      bus_src;
  logic [RW-1:0] rsel, wsel;
  logic          reg_we, a_we, b_we, sub;
  logic [DW-1:0] rdata, bus, alu_res;
  logic [DW-1:0] a_q, b_q;

  proc_ctrl #(.DW(DW), .RW(RW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .din_i     (din_i),
    .bus_src_o (bus_src),
    .rsel_o    (rsel),
    .wsel_o    (wsel),
    .reg_we_o  (reg_we),
    .a_we_o    (a_we),
    .b_we_o    (b_we),
    .sub_o     (sub),
    .done_o    (done_o)
  );

  proc_regfile #(.DW(DW), .NREG(NREG), .RW(RW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .wsel_i  (wsel),
    .wdata_i (bus),
    .rsel_i  (rsel),
    .rdata_o (rdata)
  );

  proc_alu #(.DW(DW)) u_alu (
    .a_i   (a_q),
    .b_i   (bus),
    .sub_i (sub),
    .res_o (alu_res)
  );

  always_comb begin
    unique case (bus_src)
      BUS_REG:  bus = rdata;
      BUS_TMPB: bus = b_q;
      default:  bus = din_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_we) a_q <= bus;
      if (b_we) b_q <= alu_res;
    end
  end

  assign bus_o = bus;

  AST_TEMP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(a_q) && $stable(b_q)); // R7
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !reg_we && !done_o); // R7
endmodule

// File: tb/bus_proc_tb.sv
module bus_proc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] din = '0;
  logic       done;
  logic [7:0] bus;

  int total = 0;
  int bad = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  bus_proc u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .run_i  (run),
    .din_i  (din),
    .done_o (done),
    .bus_o  (bus)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // one cycle: set inputs after a falling edge, outputs settle before the rising edge
  task automatic drive(input logic [7:0] d, input logic r);
    @(negedge clk);
    din = d;
    run = r;
    #1;
  endtask

  task automatic do_mv(input int rx, input int ry, input string tag);
    drive({2'b00, 3'(rx), 3'(ry)}, 1'b1);
    check({tag, " R9 done step0"}, {7'd0, done}, 8'd0);
    check({tag, " R6 bus step0"}, bus, {2'b00, 3'(rx), 3'(ry)});
    drive(8'h00, 1'b1);
    check({tag, " R2 bus"}, bus, model[ry]);
    check({tag, " R2 done"}, {7'd0, done}, 8'd1);
    model[rx] = model[ry];
  endtask

  task automatic read_reg(input int k, input string tag);
    logic [7:0] exp = model[k];
    do_mv(k, k, tag);
    check({tag, " readback"}, bus, exp);
  endtask

  task automatic do_mvi(input int rx, input logic [7:0] val, input string tag);
    drive({2'b01, 3'(rx), 3'b000}, 1'b1);
    check({tag, " R9 done step0"}, {7'd0, done}, 8'd0);
    drive(val, 1'b1);
    check({tag, " R3 bus"}, bus, val);
    check({tag, " R3 done"}, {7'd0, done}, 8'd1);
    model[rx] = val;
  endtask

  task automatic do_alu(input logic is_sub, input int rx, input int ry, input string tag);
    logic [7:0] a = model[rx];
    logic [7:0] b = model[ry];
    logic [7:0] r = is_sub ? 8'(a + ~b + 8'd1) : 8'(a + b);
    drive({1'b1, is_sub, 3'(rx), 3'(ry)}, 1'b1);
    check({tag, " R9 done step0"}, {7'd0, done}, 8'd0);
    drive(8'h00, 1'b1);
    check({tag, " R6 bus Rx"}, bus, a);
    check({tag, " R9 done step1"}, {7'd0, done}, 8'd0);
    drive(8'h00, 1'b1);
    check({tag, " R6 bus Ry"}, bus, b);
    check({tag, " R9 done step2"}, {7'd0, done}, 8'd0);
    drive(8'h00, 1'b1);
    check({tag, " R6 bus result"}, bus, r);
    check({tag, " R9 done step3"}, {7'd0, done}, 8'd1);
    model[rx] = r;
  endtask

  task automatic t_reset;
    drive(8'h5a, 1'b0);
    check("R8 done after reset", {7'd0, done}, 8'd0);
    check("R8 bus at step0", bus, 8'h5a);
    for (int k = 0; k < 8; k++) read_reg(k, "R8 reg zero");
  endtask

  task automatic t_load;
    for (int k = 0; k < 8; k++) do_mvi(k, 8'(8'h11 * (k + 1) + 8'h03), "R3 load");
    for (int k = 0; k < 8; k++) read_reg(k, "R3 readback");
  endtask

  task automatic t_fields;
    do_mv(2, 5, "R1 mv R2,R5");
    read_reg(2, "R2 dest");
    read_reg(5, "R2 src kept");
    do_mv(6, 1, "R1 mv R6,R1");
    read_reg(6, "R1 field rx");
    read_reg(1, "R1 field ry");
  endtask

  task automatic t_arith;
    do_mvi(1, 8'hf0, "R4 set");
    do_mvi(3, 8'h25, "R4 set");
    do_alu(1'b0, 1, 3, "R4 add wrap");
    read_reg(1, "R4 add result");
    read_reg(3, "R4 src kept");
    do_mvi(4, 8'h10, "R5 set");
    do_mvi(6, 8'h7c, "R5 set");
    do_alu(1'b1, 4, 6, "R5 sub neg");
    read_reg(4, "R5 sub result");
    do_alu(1'b1, 6, 4, "R5 sub pos");
    read_reg(6, "R5 sub result2");
  endtask

  task automatic t_same_reg;
    do_mvi(0, 8'h43, "R10 set");
    do_alu(1'b0, 0, 0, "R10 add self");
    read_reg(0, "R10 doubled");
    do_mvi(7, 8'h9e, "R10 set");
    do_alu(1'b1, 7, 7, "R10 sub self");
    read_reg(7, "R10 cleared");
  endtask

  task automatic t_run_low;
    logic [7:0] a, b, r;
    // idle with a load-immediate word present: nothing may change
    for (int i = 0; i < 4; i++) begin
      drive({2'b01, 3'd2, 3'd0}, 1'b0);
      check("R7 idle done", {7'd0, done}, 8'd0);
      check("R7 idle bus din", bus, {2'b01, 3'd2, 3'd0});
    end
    read_reg(2, "R7 idle no write");
    // pause an add in step 1
    do_mvi(5, 8'h31, "R7 set");
    do_mvi(3, 8'h0e, "R7 set");
    a = model[5];
    b = model[3];
    r = 8'(a + b);
    drive({2'b10, 3'd5, 3'd3}, 1'b1);
    for (int i = 0; i < 3; i++) begin
      drive(8'hff, 1'b0);
      check("R7 pause bus Rx", bus, a);
      check("R7 pause done", {7'd0, done}, 8'd0);
    end
    drive(8'h00, 1'b1);
    check("R7 resume bus Rx", bus, a);
    drive(8'h00, 1'b0);
    check("R7 pause step2 bus", bus, b);
    drive(8'h00, 1'b1);
    check("R7 resume step2 bus", bus, b);
    drive(8'h00, 1'b0);
    check("R7 pause step3 bus", bus, r);
    check("R7 pause step3 done", {7'd0, done}, 8'd0);
    drive(8'h00, 1'b1);
    check("R7 final bus", bus, r);
    check("R9 final done", {7'd0, done}, 8'd1);
    model[5] = r;
    read_reg(5, "R7 result after pause");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_load;
    t_fields;
    t_arith;
    t_same_reg;
    t_run_low;
    drive(8'h00, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule